// File: doc/BRIEF.md
# Fused Shift-and-Merge Integer Unit

This block is an integer execution stage for three-operand fused logic operations. Each operation has two parts. The first part either shifts the second source by an amount taken from the first source, or ANDs those two sources together. The second part combines that intermediate value with the third source, by AND (masking) or by OR (merging). A 4-bit operation code selects one of five such operations.

The stage works on 32-bit full-precision operands or on 16-bit half-precision operands. A per-source invert modifier complements a source before it is used. Inputs are sampled when `inVal` is high. The result, an illegal-operation flag and `outVal` appear one clock later. Register-file access, operand fetch and instruction-word decoding belong to the surrounding pipeline.

Top module: `shift_merge_unit`

## Requirements
- R1: Op code 4'b1000 yields (B >> A) & C, where A, B and C are the conditioned first, second and third sources.
- R2: Op code 4'b1001 yields (B << A) & C.
- R3: Op code 4'b1010 yields (B >> A) | C.
- R4: Op code 4'b1011 yields (B << A) | C.
- R5: Op code 4'b1100 yields (B & A) | C.
- R6: Right shifts are logical and fill with zeros. The shift amount is the low 5 bits of A in full precision and the low 4 bits of A in half precision. All higher bits of A have no effect on the amount.
- R7: With `fullPrec` low, every source is truncated to its low 16 bits and the shifted value is truncated to 16 bits. `result[31:16]` is zero.
- R8: When `negA`, `negB` or `negC` is high, that source is bitwise inverted before truncation and before any use. This includes the use of A as the shift amount.
- R9: Any op code other than 4'b1000 to 4'b1100 gives `result` = 0 with `illegalOp` = 1. A legal op code gives `illegalOp` = 0.
- R10: `outVal` is high in exactly the cycle after a cycle with `inVal` high. `result` and `illegalOp` show that operation's outcome in the same cycle, so operations may be issued back to back.
- R11: In a cycle with `inVal` low, `result` and `illegalOp` keep their values and `outVal` falls.
- R12: After reset, `outVal`, `result` and `illegalOp` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inVal | input | 1 | Operation valid this cycle |
| opCode | input | 4 | Operation select |
| fullPrec | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| srcA | input | 32 | First source (shift amount or AND operand) |
| srcB | input | 32 | Second source (value shifted or ANDed) |
| srcC | input | 32 | Third source (mask or merge operand) |
| negA | input | 1 | Invert first source |
| negB | input | 1 | Invert second source |
| negC | input | 1 | Invert third source |
| outVal | output | 1 | Result valid |
| result | output | 32 | Operation result, zero-extended in half precision |
| illegalOp | output | 1 | Op code was not one of the five defined |

## Verification
Three functions can act in the same cycle: inverting a source, truncating to half width, and taking the shift amount from A.

These collide when A is inverted in half precision. In that case the shift amount must come from the low four bits of the complemented A, and its upper bits must be ignored. Likewise, a left shift in half precision must lose the bits pushed past bit 15, which happens together with the final combine. The bench drives these combinations on purpose, with A values whose upper bits would change the answer if they leaked through. It judges the result against a model built from the requirements alone.

// File: rtl/shift_merge_pkg.sv
package shift_merge_pkg;
  localparam int FULL_W = 32;
  localparam int HALF_W = 16;

  typedef enum logic [3:0] {
    OP_SHR_AND = 4'b1000,
    OP_SHL_AND = 4'b1001,
    OP_SHR_OR  = 4'b1010,
    OP_SHL_OR  = 4'b1011,
    OP_AND_OR  = 4'b1100
  } opSel_e;

  typedef struct packed {
    logic doShift;
    logic shiftLeft;
    logic mergeOr;
    logic illegal;
  } ctlStrobes_t;
endpackage

// File: rtl/shift_merge_ctrl.sv
module shift_merge_ctrl
  import shift_merge_pkg::*;
(
  input  logic [3:0]  opCode,
  output ctlStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    case (opCode)
      OP_SHR_AND: begin strobes.doShift = 1'b1; end
      OP_SHL_AND: begin strobes.doShift = 1'b1; strobes.shiftLeft = 1'b1; end
      OP_SHR_OR:  begin strobes.doShift = 1'b1; strobes.mergeOr = 1'b1; end
      OP_SHL_OR:  begin strobes.doShift = 1'b1; strobes.shiftLeft = 1'b1; strobes.mergeOr = 1'b1; end
      OP_AND_OR:  begin strobes.mergeOr = 1'b1; end
      default:    begin strobes.illegal = 1'b1; end
    endcase
  end
endmodule

// File: rtl/shift_merge_datapath.sv
module shift_merge_datapath
  import shift_merge_pkg::*;
#(
  parameter int FW = FULL_W,
  parameter int HW = HALF_W
) (
  input  logic [FW-1:0] srcA,
  input  logic [FW-1:0] srcB,
  input  logic [FW-1:0] srcC,
  input  logic          negA,
  input  logic          negB,
  input  logic          negC,
  input  logic          fullPrec,
  input  ctlStrobes_t   strobes,
  output logic [FW-1:0] value
);
  localparam int SH_FULL = $clog2(FW);
  localparam int SH_HALF = $clog2(HW);
  localparam int NSRC    = 3;

  logic [FW-1:0] widthMask;
  logic [FW-1:0] rawSrc [NSRC];
  logic [FW-1:0] cond   [NSRC];
  logic [NSRC-1:0] negVec;

  assign widthMask = fullPrec ? {FW{1'b1}} : {{(FW-HW){1'b0}}, {HW{1'b1}}};
  assign rawSrc[0] = srcA;
  assign rawSrc[1] = srcB;
  assign rawSrc[2] = srcC;
  assign negVec    = {negC, negB, negA};

  // invert first, then truncate to the active width
  for (genvar i = 0; i < NSRC; i++) begin : g_cond
    assign cond[i] = (rawSrc[i] ^ {FW{negVec[i]}}) & widthMask;
  end

  logic [SH_FULL-1:0] shAmt;
  assign shAmt = fullPrec ? cond[0][SH_FULL-1:0]
                          : {{(SH_FULL-SH_HALF){1'b0}}, cond[0][SH_HALF-1:0]};

  // logarithmic shifter, one stage per amount bit
  logic [FW-1:0] stg [SH_FULL+1];
  assign stg[0] = cond[1];
  for (genvar s = 0; s < SH_FULL; s++) begin : g_stage
    localparam int STEP = 1 << s;
    logic [FW-1:0] moved;
    assign moved = strobes.shiftLeft ? (stg[s] << STEP) : (stg[s] >> STEP);
    assign stg[s+1] = shAmt[s] ? moved : stg[s];
  end

  logic [FW-1:0] firstStep;
  logic [FW-1:0] combined;

  always_comb begin
    if (strobes.doShift) firstStep = stg[SH_FULL] & widthMask;
    else                 firstStep = cond[1] & cond[0];
    combined = strobes.mergeOr ? (firstStep | cond[2]) : (firstStep & cond[2]);
    value    = strobes.illegal ? '0 : combined;
  end
endmodule

// File: rtl/shift_merge_unit.sv
module shift_merge_unit
  import shift_merge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inVal,
  input  logic [3:0]  opCode,
  input  logic        fullPrec,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  input  logic [31:0] srcC,
  input  logic        negA,
  input  logic        negB,
  input  logic        negC,
  output logic        outVal,
  output logic [31:0] result,
  output logic        illegalOp
);
  ctlStrobes_t strobes;
  logic [31:0] nextValue;

  shift_merge_ctrl u_ctrl (
    .opCode  (opCode),
    .strobes (strobes)
  );

  shift_merge_datapath #(.FW(FULL_W), .HW(HALF_W)) u_dp (
    .srcA     (srcA),
    .srcB     (srcB),
    .srcC     (srcC),
    .negA     (negA),
    .negB     (negB),
    .negC     (negC),
    .fullPrec (fullPrec),
    .strobes  (strobes),
    .value    (nextValue)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outVal    <= 1'b0;
      result    <= '0;
      illegalOp <= 1'b0;
    end else begin
      outVal <= inVal;
      if (inVal) begin
        result    <= nextValue;
        illegalOp <= strobes.illegal;
      end
    end
  end
endmodule

// File: rtl/shift_merge_checker.sv
module shift_merge_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        inVal,
  input logic [3:0]  opCode,
  input logic        fullPrec,
  input logic        outVal,
  input logic [31:0] result,
  input logic        illegalOp
);
  logic legalCode;
  assign legalCode = (opCode >= 4'b1000) && (opCode <= 4'b1100);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    inVal |=> outVal); // R10
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !inVal |=> !outVal); // R11
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !inVal |=> ($stable(result) && $stable(illegalOp))); // R11
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (inVal && !fullPrec) |=> (result[31:16] == 16'h0)); // R7
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (inVal && !legalCode) |=> (illegalOp && result == 32'h0)); // R9
  AST_LEGAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (inVal && legalCode) |=> !illegalOp); // R9
endmodule

bind shift_merge_unit shift_merge_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inVal     (inVal),
  .opCode    (opCode),
  .fullPrec  (fullPrec),
  .outVal    (outVal),
  .result    (result),
  .illegalOp (illegalOp)
);

// File: tb/tb_shift_merge_unit.sv
`timescale 1ns/1ps
module tb_shift_merge_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inVal = 1'b0;
  logic [3:0]  opCode = 4'h0;
  logic        fullPrec = 1'b1;
  logic [31:0] srcA = '0, srcB = '0, srcC = '0;
  logic        negA = 1'b0, negB = 1'b0, negC = 1'b0;
  logic        outVal;
  logic [31:0] result;
  logic        illegalOp;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shift_merge_unit dut (
    .clk(clk), .rst_n(rst_n), .inVal(inVal), .opCode(opCode), .fullPrec(fullPrec),
    .srcA(srcA), .srcB(srcB), .srcC(srcC), .negA(negA), .negB(negB), .negC(negC),
    .outVal(outVal), .result(result), .illegalOp(illegalOp)
  );

  // model written from the requirement list
  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a, b, c,
                                        input logic full, input logic na, nb, nc);
    logic [31:0] m, ca, cb, cc, first, res;
    int amt;
    m  = full ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    ca = (na ? ~a : a) & m;
    cb = (nb ? ~b : b) & m;
    cc = (nc ? ~c : c) & m;
    amt = full ? int'(ca[4:0]) : int'(ca[3:0]);
    case (op)
      4'b1000: begin first = (cb >> amt) & m; res = first & cc; end
      4'b1001: begin first = (cb << amt) & m; res = first & cc; end
      4'b1010: begin first = (cb >> amt) & m; res = first | cc; end
      4'b1011: begin first = (cb << amt) & m; res = first | cc; end
      4'b1100: begin first = cb & ca; res = first | cc; end
      default: return {1'b1, 32'h0};
    endcase
    return {1'b0, res};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one operation and check it one clock later
  task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a, b, c,
                        input logic full, input logic na = 0, nb = 0, nc = 0);
    logic [32:0] exp;
    exp = model(op, a, b, c, full, na, nb, nc);
    @(negedge clk);
    inVal = 1; opCode = op; srcA = a; srcB = b; srcC = c; fullPrec = full;
    negA = na; negB = nb; negC = nc;
    @(posedge clk); #1;
    check({tag, " result"}, result, exp[31:0]);
    check({tag, " illegal"}, {31'h0, illegalOp}, {31'h0, exp[32]});
    check({tag, " outVal"}, {31'h0, outVal}, 32'h1);
    @(negedge clk);
    inVal = 0; negA = 0; negB = 0; negC = 0;
  endtask

  task automatic test_reset();
    #1;
    check("R12 outVal", {31'h0, outVal}, 32'h0);
    check("R12 result", result, 32'h0);
    check("R12 illegal", {31'h0, illegalOp}, 32'h0);
  endtask

  task automatic test_ops();
    run_op("R1 shr_and", 4'b1000, 32'd8, 32'hF0F0_1234, 32'h00FF_FF00, 1);
    run_op("R2 shl_and", 4'b1001, 32'd12, 32'h000A_BCDE, 32'hFFF0_0F00, 1);
    run_op("R3 shr_or", 4'b1010, 32'd31, 32'h8000_0000, 32'h0000_0100, 1);
    run_op("R4 shl_or", 4'b1011, 32'd4, 32'h1234_5678, 32'h0000_000F, 1);
    run_op("R5 and_or", 4'b1100, 32'hFF00_FF00, 32'h0F0F_0F0F, 32'h1000_0001, 1);
  endtask

  task automatic test_shift_amount();
    run_op("R6 logical_fill", 4'b1010, 32'd4, 32'hF000_0000, 32'h0, 1);
    run_op("R6 amount_low5", 4'b1000, 32'hFFFF_FFE3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    run_op("R6 amount_low4", 4'b1011, 32'h0000_0013, 32'h0000_0001, 32'h0, 0);
  endtask

  task automatic test_half();
    run_op("R7 shl_overflow", 4'b1011, 32'd8, 32'h1234_ABCD, 32'hFFFF_0000, 0);
    run_op("R7 and_or_trunc", 4'b1100, 32'hFFFF_FFFF, 32'hABCD_1234, 32'hFFFF_0001, 0);
  endtask

  task automatic test_invert();
    run_op("R8 negB_full", 4'b1010, 32'd0, 32'h0000_FFFF, 32'h0, 1, 0, 1, 0);
    run_op("R8 negC_mask", 4'b1000, 32'd0, 32'hFFFF_FFFF, 32'h00FF_0000, 1, 0, 0, 1);
    run_op("R8 negA_half_amt", 4'b1001, 32'hFFFF_FFF3, 32'h0000_0001, 32'hFFFF_FFFF, 0, 1, 0, 0);
    run_op("R8 all_neg_half", 4'b1100, 32'h0000_00F0, 32'h0000_0F0F, 32'h0000_FFFE, 0, 1, 1, 1);
  endtask

  task automatic test_illegal();
    run_op("R9 code_0000", 4'b0000, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    run_op("R9 code_1101", 4'b1101, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    run_op("R9 code_1111_half", 4'b1111, 32'h1, 32'hFFFF, 32'hFFFF, 0);
    run_op("R9 legal_after", 4'b1011, 32'h1, 32'h1, 32'h0, 1);
  endtask

  task automatic test_back_to_back();
    logic [32:0] e1, e2;
    e1 = model(4'b1001, 32'd1, 32'h0000_0003, 32'hFFFF_FFFF, 1, 0, 0, 0);
    e2 = model(4'b1000, 32'd2, 32'h0000_0F00, 32'hFFFF_FFFF, 1, 0, 0, 0);
    @(negedge clk);
    inVal = 1; opCode = 4'b1001; srcA = 32'd1; srcB = 32'h3; srcC = 32'hFFFF_FFFF; fullPrec = 1;
    @(negedge clk);
    check("R10 first_result", result, e1[31:0]);
    check("R10 first_valid", {31'h0, outVal}, 32'h1);
    opCode = 4'b1000; srcA = 32'd2; srcB = 32'h0F00;
    @(negedge clk);
    check("R10 second_result", result, e2[31:0]);
    check("R10 second_valid", {31'h0, outVal}, 32'h1);
    inVal = 0;
  endtask

  task automatic test_hold();
    logic [32:0] e;
    e = model(4'b1011, 32'd3, 32'h0000_0011, 32'h0, 1, 0, 0, 0);
    run_op("R11 setup", 4'b1011, 32'd3, 32'h11, 32'h0, 1);
    @(negedge clk);
    inVal = 0; opCode = 4'b1111; srcB = 32'hDEAD_BEEF; srcC = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    check("R11 result_held", result, e[31:0]);
    check("R11 illegal_held", {31'h0, illegalOp}, 32'h0);
    check("R11 valid_low", {31'h0, outVal}, 32'h0);
  endtask

  initial begin
    test_reset();
    #7 rst_n = 1;
    test_ops();
    test_shift_amount();
    test_half();
    test_invert();
    test_illegal();
    test_back_to_back();
    test_hold();
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule